// File: doc/BRIEF.md
# RDS Block Syndrome Synchronizer

This block takes a serial broadcast-data bitstream, one bit per cycle in which a valid strobe is high. It keeps the last 26 received bits and computes a 10-bit syndrome over them. From that syndrome it recognises one of six offset words: A, B, C, C', D and E.

While it is not locked, it evaluates the syndrome at every bit position. It declares lock when a recognised block is followed, exactly 26 bits later, by a recognised block that is a legal successor of the first. Once locked, it evaluates only at block boundaries. It follows a one-bit slip of the boundary in either direction.

Every block that is evaluated while locked is reported on a one-cycle strobe, together with its offset identity, a validity flag and its 16 information bits. A loss-of-sync pulse from a separate flywheel counter, or a restart pulse, drops lock and resumes the search.

Top module: `rds_block_sync`

## Requirements
- R1: A block is the last 26 accepted bits, with the first received bit as the highest-order coefficient. The syndrome is that word modulo x^10+x^8+x^7+x^5+x^4+x^3+1, and a block carries an offset when its syndrome equals that offset word: A=0x0FC, B=0x198, C=0x168, C'=0x350, D=0x1B4, E=0x000. The identity is reported on `blk_id_o` as A=0, B=1, C=2, C'=3, D=4, E=5, and `info_o` carries the first 16 bits of the block.
- R2: No offset is recognised until 26 bits have been accepted since reset.
- R3: In search, a block is tested at every accepted bit. Lock is declared when a recognised block is followed 26 bits later by a recognised legal successor. In the cycle after that bit, `sync_o` rises and the second block is reported with `blk_ok_o`=1.
- R4: The legal successor order is A to B, B to C or C', C or C' to D, D to A or E, and E to A or E.
- R5: While locked, blocks are reported only at block boundaries, once per 26 bits. Offset matches between boundaries produce no report.
- R6: An E block is reported valid when `rbds_mode_i`=1. It is reported at its boundary with `blk_ok_o`=0 when `rbds_mode_i`=0, and in that mode it never acts as a search candidate.
- R7: While locked, a legal block that ends one bit before the boundary is reported valid at the boundary with its own data, and the next boundary falls 25 bits after that.
- R8: While locked, a legal block that ends one bit after the boundary is reported valid at that bit, and the next boundary falls 26 bits after it.
- R9: While locked, if no legal block is found at the boundary or one bit after it, a block is reported one bit after the boundary with `blk_ok_o`=0. It carries the predicted successor identity (E predicts A) and the data held at the boundary, and the boundary position is kept.
- R10: A high `sync_loss_i` or `restart_i` clears `sync_o` in the next cycle and restarts the search from an empty candidate set.
- R11: After reset, `sync_o`, `blk_stb_o`, `blk_ok_o` and `info_o` are zero.
- R12: `blk_stb_o` is high only in the cycle after an accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | High when bit_i carries a new bit |
| rbds_mode_i | input | 1 | 1 treats E blocks as valid |
| restart_i | input | 1 | Drops lock and restarts the search |
| sync_loss_i | input | 1 | Loss-of-sync indication from the flywheel |
| blk_stb_o | output | 1 | One-cycle block report strobe |
| blk_id_o | output | 3 | Offset identity of the reported block |
| blk_ok_o | output | 1 | Reported block is valid |
| info_o | output | 16 | Information bits of the reported block |
| sync_o | output | 1 | Lock status |

## Verification
A wrong boundary counter shows up as a report landing on the wrong bit index. Either an early or late slip is taken by mistake, or a report arrives in the wrong cycle, and it is visible within one block of 26 bits. A corrupted candidate slot or predecessor identity shows as lock failing to come on the second block, or as a valid block reported with `blk_ok_o`=0 on the very next boundary. A fault in the mode gating of E blocks is visible on the first E block after a D block.

// File: rtl/rds_sync_pkg.sv
`timescale 1ns/1ps
package rds_sync_pkg;
  localparam int BLK_W  = 26;
  localparam int CHK_W  = 10;
  localparam int INFO_W = BLK_W - CHK_W;
  localparam int ID_W   = 3;
  localparam int NUM_OFS = 6;
  localparam int CNT_W  = $clog2(BLK_W + 2);
  // generator without its x^10 term
  localparam logic [CHK_W-1:0] GEN_LOW = 10'h1B9;

  typedef enum logic [ID_W-1:0] {
    ID_A = 3'd0, ID_B = 3'd1, ID_C = 3'd2, ID_CP = 3'd3, ID_D = 3'd4, ID_E = 3'd5
  } blk_id_e;

  function automatic logic [CHK_W-1:0] offset_of(input blk_id_e id);
    logic [CHK_W-1:0] o;
    case (id)
      ID_A:    o = 10'h0FC;
      ID_B:    o = 10'h198;
      ID_C:    o = 10'h168;
      ID_CP:   o = 10'h350;
      ID_D:    o = 10'h1B4;
      default: o = 10'h000;
    endcase
    return o;
  endfunction

  // remainder of the window polynomial modulo the generator
  function automatic logic [CHK_W-1:0] calc_synd(input logic [BLK_W-1:0] w);
    logic [CHK_W-1:0] r;
    logic msb;
    r = '0;
    for (int i = BLK_W - 1; i >= 0; i--) begin
      msb = r[CHK_W-1];
      r   = {r[CHK_W-2:0], w[i]};
      if (msb) r = r ^ GEN_LOW;
    end
    return r;
  endfunction

  function automatic logic legal_succ(input blk_id_e p, input blk_id_e n);
    logic ok;
    case (p)
      ID_A:        ok = (n == ID_B);
      ID_B:        ok = (n == ID_C) || (n == ID_CP);
      ID_C, ID_CP: ok = (n == ID_D);
      ID_D, ID_E:  ok = (n == ID_A) || (n == ID_E);
      default:     ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic blk_id_e pred_succ(input blk_id_e p);
    blk_id_e n;
    case (p)
      ID_A:        n = ID_B;
      ID_B:        n = ID_C;
      ID_C, ID_CP: n = ID_D;
      default:     n = ID_A;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/rds_bit_window.sv
`timescale 1ns/1ps
module rds_bit_window #(
  parameter int W = rds_sync_pkg::BLK_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic         bit_vld_i,
  output logic [W-1:0] win_nxt_o,
  output logic         filled_nxt_o
);
  localparam int FW = $clog2(W + 1);

  logic [W-1:0]  win_q;
  logic [FW-1:0] fill_q;

  assign win_nxt_o    = {win_q[W-2:0], bit_i};
  assign filled_nxt_o = (fill_q >= FW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_vld_i) begin
      win_q <= win_nxt_o;
      if (fill_q != FW'(W)) fill_q <= fill_q + FW'(1);
    end
  end
endmodule

// File: rtl/rds_offset_detect.sv
`timescale 1ns/1ps
module rds_offset_detect
  import rds_sync_pkg::*;
(
  input  logic [BLK_W-1:0] win_i,
  input  logic             rbds_mode_i,
  output logic             hit_o,
  output blk_id_e          id_o,
  output logic             valid_o
);
  logic [CHK_W-1:0]   synd;
  logic [NUM_OFS-1:0] match;

  assign synd = calc_synd(win_i);

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    assign match[g] = (synd == offset_of(blk_id_e'(ID_W'(g))));
  end

  always_comb begin
    id_o = ID_A;
    for (int i = 0; i < NUM_OFS; i++)
      if (match[i]) id_o = blk_id_e'(ID_W'(i));
  end

  assign hit_o   = |match;
  // R6: E only counts in the extended mode
  assign valid_o = hit_o && ((id_o != ID_E) || rbds_mode_i);
endmodule

// File: rtl/rds_sync_ctrl.sv
`timescale 1ns/1ps
module rds_sync_ctrl
  import rds_sync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              restart_i,
  input  logic              sync_loss_i,
  input  logic              filled_i,
  input  logic              hit_i,
  input  blk_id_e           id_i,
  input  logic              valid_i,
  input  logic [INFO_W-1:0] info_i,
  output logic              stb_o,
  output blk_id_e           id_o,
  output logic              ok_o,
  output logic [INFO_W-1:0] info_o,
  output logic              sync_o
);
  localparam logic [CNT_W-1:0] C_EARLY = CNT_W'(BLK_W - 1);
  localparam logic [CNT_W-1:0] C_NOM   = CNT_W'(BLK_W);
  localparam logic [CNT_W-1:0] C_LATE  = CNT_W'(BLK_W + 1);

  logic              sync_q, stb_q, ok_q;
  blk_id_e           id_q, last_q, early_id_q;
  logic [INFO_W-1:0] info_q, early_info_q, pend_info_q;
  logic [CNT_W-1:0]  cnt_q, ph_q;
  logic              early_q;
  logic [BLK_W-1:0]  slot_v_q;
  blk_id_e           slot_id_q [BLK_W];

  logic [CNT_W-1:0] cnt_inc;
  logic legal, e_rds, slot_hit;

  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign legal    = valid_i && legal_succ(last_q, id_i);
  assign e_rds    = hit_i && (id_i == ID_E) && !valid_i && legal_succ(last_q, ID_E);
  assign slot_hit = slot_v_q[ph_q] && valid_i && legal_succ(slot_id_q[ph_q], id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0; stb_q <= 1'b0; ok_q <= 1'b0;
      id_q <= ID_A; last_q <= ID_A; early_id_q <= ID_A;
      info_q <= '0; early_info_q <= '0; pend_info_q <= '0;
      cnt_q <= '0; ph_q <= '0; early_q <= 1'b0; slot_v_q <= '0;
      for (int i = 0; i < BLK_W; i++) slot_id_q[i] <= ID_A;
    end else begin
      stb_q <= 1'b0;
      if (restart_i || sync_loss_i) begin                 // R10
        sync_q <= 1'b0; cnt_q <= '0; ph_q <= '0;
        early_q <= 1'b0; slot_v_q <= '0;
      end else if (bit_vld_i && !sync_q) begin
        if (filled_i) begin                               // R2
          if (slot_hit) begin                             // R3
            sync_q <= 1'b1; stb_q <= 1'b1; ok_q <= 1'b1;
            id_q <= id_i; info_q <= info_i; last_q <= id_i;
            cnt_q <= '0; early_q <= 1'b0; slot_v_q <= '0; ph_q <= '0;
          end else begin
            slot_v_q[ph_q]  <= valid_i;
            slot_id_q[ph_q] <= id_i;
            ph_q <= (ph_q == CNT_W'(BLK_W - 1)) ? '0 : ph_q + CNT_W'(1);
          end
        end
      end else if (bit_vld_i) begin
        cnt_q <= cnt_inc;
        if (cnt_inc == C_EARLY) begin                     // R7 candidate
          early_q <= legal; early_id_q <= id_i; early_info_q <= info_i;
        end else if (cnt_inc == C_NOM) begin
          early_q <= 1'b0;
          if (legal) begin
            stb_q <= 1'b1; ok_q <= 1'b1; id_q <= id_i; info_q <= info_i;
            last_q <= id_i; cnt_q <= '0;
          end else if (early_q) begin
            stb_q <= 1'b1; ok_q <= 1'b1; id_q <= early_id_q; info_q <= early_info_q;
            last_q <= early_id_q; cnt_q <= CNT_W'(1);
          end else if (e_rds) begin                       // R6
            stb_q <= 1'b1; ok_q <= 1'b0; id_q <= ID_E; info_q <= info_i;
            last_q <= ID_E; cnt_q <= '0;
          end else begin
            pend_info_q <= info_i;
          end
        end else if (cnt_inc == C_LATE) begin
          stb_q <= 1'b1; info_q <= legal ? info_i : pend_info_q;
          if (legal) begin                                // R8
            ok_q <= 1'b1; id_q <= id_i; last_q <= id_i; cnt_q <= '0;
          end else begin                                  // R9
            ok_q <= 1'b0; id_q <= pred_succ(last_q); last_q <= pred_succ(last_q);
            cnt_q <= CNT_W'(1);
          end
        end
      end
    end
  end

  assign stb_o  = stb_q;
  assign id_o   = id_q;
  assign ok_o   = ok_q;
  assign info_o = info_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/rds_block_sync.sv
`timescale 1ns/1ps
module rds_block_sync
  import rds_sync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  input  logic              rbds_mode_i,
  input  logic              restart_i,
  input  logic              sync_loss_i,
  output logic              blk_stb_o,
  output logic [ID_W-1:0]   blk_id_o,
  output logic              blk_ok_o,
  output logic [INFO_W-1:0] info_o,
  output logic              sync_o
);
  logic [BLK_W-1:0] win_nxt;
  logic filled, hit, valid;
  blk_id_e det_id, rep_id;

  rds_bit_window #(.W(BLK_W)) u_win (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i,
    .win_nxt_o(win_nxt), .filled_nxt_o(filled)
  );

  rds_offset_detect u_det (
    .win_i(win_nxt), .rbds_mode_i,
    .hit_o(hit), .id_o(det_id), .valid_o(valid)
  );

  rds_sync_ctrl u_ctrl (
    .clk_i, .rst_ni, .bit_vld_i, .restart_i, .sync_loss_i,
    .filled_i(filled), .hit_i(hit), .id_i(det_id), .valid_i(valid),
    .info_i(win_nxt[BLK_W-1:CHK_W]),
    .stb_o(blk_stb_o), .id_o(rep_id), .ok_o(blk_ok_o), .info_o(info_o), .sync_o(sync_o)
  );

  assign blk_id_o = rep_id;
endmodule

// File: rtl/rds_sync_chk.sv
`timescale 1ns/1ps
module rds_sync_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_vld_i,
  input logic       rbds_mode_i,
  input logic       restart_i,
  input logic       sync_loss_i,
  input logic       blk_stb_o,
  input logic [2:0] blk_id_o,
  input logic       blk_ok_o,
  input logic       sync_o
);
  a_r5_report_only_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_stb_o |-> sync_o);

  a_r12_stb_after_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> !blk_stb_o);

  a_r10_drop_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i || sync_loss_i) |=> (!sync_o && !blk_stb_o));

  a_r6_e_invalid_rds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && !rbds_mode_i) |=> !(blk_stb_o && blk_id_o == 3'd5 && blk_ok_o));

  a_r3_lock_reports_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> (blk_stb_o && blk_ok_o));

  a_r1_id_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_stb_o |-> (blk_id_o <= 3'd5));
endmodule

bind rds_block_sync rds_sync_chk u_chk (
  .clk_i, .rst_ni, .bit_vld_i, .rbds_mode_i, .restart_i, .sync_loss_i,
  .blk_stb_o, .blk_id_o, .blk_ok_o, .sync_o
);

// File: tb/sim_rds_block_sync.sv
`timescale 1ns/1ps
module sim_rds_block_sync;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0, bit_vld_i = 1'b0, rbds_mode_i = 1'b0;
  logic restart_i = 1'b0, sync_loss_i = 1'b0;
  logic blk_stb_o, blk_ok_o, sync_o;
  logic [2:0] blk_id_o;
  logic [15:0] info_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int bitno = 0, ev_n = 0;
  int ev_bit [32];
  logic [2:0] ev_id [32];
  logic ev_ok [32];
  logic [15:0] ev_info [32];

  always #10 clk = ~clk;

  rds_block_sync u0 (
    .clk_i(clk), .rst_ni, .bit_i, .bit_vld_i, .rbds_mode_i, .restart_i, .sync_loss_i,
    .blk_stb_o, .blk_id_o, .blk_ok_o, .info_o, .sync_o
  );

  // independent encoder: info * x^10 mod g, then offset added
  function automatic logic [25:0] enc(input logic [2:0] id, input logic [15:0] d);
    logic [25:0] v;
    logic [9:0] ofs;
    v = {d, 10'b0};
    for (int i = 25; i >= 10; i--)
      if (v[i]) v = v ^ (26'h5B9 << (i - 10));
    case (id)
      3'd0: ofs = 10'h0FC;
      3'd1: ofs = 10'h198;
      3'd2: ofs = 10'h168;
      3'd3: ofs = 10'h350;
      3'd4: ofs = 10'h1B4;
      default: ofs = 10'h000;
    endcase
    return {d, v[9:0] ^ ofs};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_i = b;
    bit_vld_i = 1'b1;
    @(posedge clk);
    #1;
    if (blk_stb_o && ev_n < 32) begin
      ev_bit[ev_n] = bitno; ev_id[ev_n] = blk_id_o;
      ev_ok[ev_n] = blk_ok_o; ev_info[ev_n] = info_o;
      ev_n++;
    end
    bitno++;
  endtask

  task automatic send_word(input logic [26:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_blk(input logic [2:0] id, input logic [15:0] d);
    send_word({1'b0, enc(id, d)}, 26);
  endtask

  task automatic clr_log();
    ev_n = 0;
    bitno = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld_i = 1'b0;
    end
  endtask

  task automatic chk_ev(input string req, input int k, input int b, input int id,
                        input int ok, input int d);
    if (k >= ev_n) begin
      chk(req, "report count", ev_n, k + 1);
      return;
    end
    chk(req, "report bit", ev_bit[k], b);
    chk(req, "report id", int'(ev_id[k]), id);
    chk(req, "report ok", int'(ev_ok[k]), ok);
    chk(req, "report info", int'(ev_info[k]), d);
  endtask

  task automatic pulse(input bit loss);
    @(negedge clk);
    bit_vld_i = 1'b0;
    if (loss) sync_loss_i = 1'b1; else restart_i = 1'b1;
    @(negedge clk);
    sync_loss_i = 1'b0;
    restart_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "sync after reset", int'(sync_o), 0);
    chk("R11", "stb after reset", int'(blk_stb_o), 0);
    chk("R11", "ok after reset", int'(blk_ok_o), 0);
    chk("R11", "info after reset", int'(info_o), 0);
  endtask

  // R2: all-zero stream looks like E blocks; lock is only possible from bit 51 on
  task automatic t_fill();
    rbds_mode_i = 1'b1;
    clr_log();
    send_word(27'h0, 26);
    send_word(27'h0, 14);
    chk("R2", "no lock before window filled", int'(sync_o), 0);
    chk("R2", "no report before window filled", ev_n, 0);
    idle(1);
    pulse(1'b0);
    rbds_mode_i = 1'b0;
  endtask

  task automatic t_lock();
    clr_log();
    send_word(27'h59, 7);
    send_blk(3'd0, 16'h1234);
    send_blk(3'd1, 16'hABCD);
    chk("R3", "reports during search", ev_n, 1);
    chk_ev("R3", 0, 58, 1, 1, 16'hABCD);
    chk("R3", "sync after pair", int'(sync_o), 1);
  endtask

  task automatic t_locked();
    clr_log();
    send_blk(3'd2, 16'h0001);
    send_blk(3'd4, 16'hFFFF);
    send_blk(3'd0, 16'h5A5A);
    send_blk(3'd1, 16'h0F0F);
    send_blk(3'd3, 16'h8001);
    send_blk(3'd4, 16'h7777);
    chk("R5", "one report per block", ev_n, 6);
    chk_ev("R1", 0, 25, 2, 1, 16'h0001);
    chk_ev("R4", 1, 51, 4, 1, 16'hFFFF);
    chk_ev("R4", 2, 77, 0, 1, 16'h5A5A);
    chk_ev("R5", 3, 103, 1, 1, 16'h0F0F);
    chk_ev("R4", 4, 129, 3, 1, 16'h8001);
    chk_ev("R4", 5, 155, 4, 1, 16'h7777);
  endtask

  task automatic t_e_blocks();
    rbds_mode_i = 1'b1;
    clr_log();
    send_blk(3'd5, 16'h1111);
    send_blk(3'd5, 16'h2222);
    send_blk(3'd0, 16'h3333);
    chk_ev("R6", 0, 25, 5, 1, 16'h1111);
    chk_ev("R6", 1, 51, 5, 1, 16'h2222);
    chk_ev("R4", 2, 77, 0, 1, 16'h3333);
    rbds_mode_i = 1'b0;
    clr_log();
    send_blk(3'd1, 16'h4444);
    send_blk(3'd2, 16'h4545);
    send_blk(3'd4, 16'h4646);
    send_blk(3'd5, 16'h5555);
    send_blk(3'd0, 16'h6666);
    chk("R6", "report count rds", ev_n, 5);
    chk_ev("R6", 3, 103, 5, 0, 16'h5555);
    chk_ev("R6", 4, 129, 0, 1, 16'h6666);
    chk("R6", "lock kept", int'(sync_o), 1);
  endtask

  task automatic t_corrupt();
    logic [25:0] w;
    w = enc(3'd1, 16'h2468) ^ 26'h8;
    clr_log();
    send_word({1'b0, w}, 26);
    send_blk(3'd2, 16'h1357);
    chk_ev("R9", 0, 26, 1, 0, 16'h2468);
    chk_ev("R9", 1, 51, 2, 1, 16'h1357);
  endtask

  task automatic t_slip_early();
    logic [25:0] w;
    w = enc(3'd4, 16'h0D0D);
    clr_log();
    send_word({1'b0, w}, 25);
    send_blk(3'd0, 16'hA0A0);
    send_blk(3'd1, 16'hB0B0);
    chk_ev("R9", 0, 26, 4, 0, int'(w[24:9]));
    chk_ev("R7", 1, 51, 0, 1, 16'hA0A0);
    chk_ev("R7", 2, 76, 1, 1, 16'hB0B0);
  endtask

  task automatic t_slip_late();
    clr_log();
    send_bit(1'b1);
    send_blk(3'd2, 16'hC0C0);
    send_blk(3'd4, 16'hD0D0);
    chk_ev("R8", 0, 26, 2, 1, 16'hC0C0);
    chk_ev("R8", 1, 52, 4, 1, 16'hD0D0);
  endtask

  task automatic t_loss();
    idle(3);
    chk("R12", "no strobe while idle", int'(blk_stb_o), 0);
    pulse(1'b1);
    chk("R10", "sync after loss pulse", int'(sync_o), 0);
    clr_log();
    send_blk(3'd0, 16'h0101);
    chk("R10", "single block after loss gives no report", ev_n, 0);
    send_blk(3'd1, 16'h0202);
    chk_ev("R10", 0, 51, 1, 1, 16'h0202);
    chk("R10", "relock", int'(sync_o), 1);
    idle(1);
    pulse(1'b0);
    chk("R10", "sync after restart", int'(sync_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_fill();
    t_lock();
    t_locked();
    t_e_blocks();
    t_corrupt();
    t_slip_early();
    t_slip_late();
    t_loss();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule